// File: doc/BRIEF.md
# Asynchronous Read Handshake Link

This block carries single-word reads across an unclocked link between two parts of a chip that run on unrelated clocks. One side, the requester, takes a read command with an address. It returns the word found at that address as a one-cycle pulse. The other side, the responder, sits next to a small synchronous memory array and answers the read. The two sides share one set of address/data lines and three control wires: a read request, a data-ready flag and an acknowledge that either side may raise.

Each read runs a fully interlocked four-phase exchange twice. The first exchange moves the address from requester to responder. The second moves the data word back. Each side is a synchronous state machine. Every control wire entering a side passes through a two-flop synchronizer first. The shared lines are modelled as two one-way buses, each with its own drive enable. A driver turns its enable on one clock before it raises its control wire, so the receiver latches only settled values.

The memory is loaded through a plain write port in the responder's clock domain. A stall input, also in that domain, holds the responder before it drives the data. This lets any memory latency be imposed on the exchange.

Top module: `async_rd_link`

## Requirements
- R1: While either reset is high and after both are released, `cmd_ready` is 1, `rsp_valid` is 0 and `bus_rreq`, `bus_drdy` and `bus_ack` are all 0.
- R2: A command accepted with address A returns the word at A as `rsp_data`, on a `rsp_valid` pulse exactly one `req_clk` cycle long.
- R3: A command is accepted only when `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` drops in the next cycle and stays 0 until the response pulse has been issued. `cmd_valid` is ignored while `cmd_ready` is 0: it starts no further transaction and causes no extra response.
- R4: The read request wire is high only while the requester drives the address lines.
- R5: The control wires follow a fixed order. The request falls only while acknowledge is high. Data-ready rises only while the request is low. Data-ready falls only while acknowledge is high.
- R6: The data-ready wire is high only while the responder drives the data lines. The two drive enables are never high together.
- R7: Holding `mem_stall` high for any number of `mem_clk` cycles delays the data phase but does not change the returned word.
- R8: When `rsp_valid` is issued, all three control wires are already low.
- R9: When `fill_en` is high at a `mem_clk` edge, `fill_data` is written to memory word `fill_addr`. Later reads of that word return the new value.
- R10: Commands issued back to back, each at the first cycle `cmd_ready` returns, each complete with their own address's data and in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_clk | input | 1 | Requester clock |
| req_rst | input | 1 | Synchronous active-high reset, requester domain |
| cmd_valid | input | 1 | Read command present |
| cmd_addr | input | ADDR_W | Word address of the read |
| cmd_ready | output | 1 | Requester idle, command can be taken |
| rsp_valid | output | 1 | One-cycle pulse, read data valid |
| rsp_data | output | DATA_W | Word returned by the read |
| mem_clk | input | 1 | Responder and memory clock |
| mem_rst | input | 1 | Synchronous active-high reset, responder domain |
| fill_en | input | 1 | Memory write strobe |
| fill_addr | input | ADDR_W | Memory write address |
| fill_data | input | DATA_W | Memory write data |
| mem_stall | input | 1 | Holds the responder before it drives data |
| bus_rreq | output | 1 | Observed read request wire |
| bus_drdy | output | 1 | Observed data-ready wire |
| bus_ack | output | 1 | Observed acknowledge wire (either side) |

## Verification
A requester stuck in a wait state shows at once as `cmd_ready` staying low with no `rsp_valid` pulse. A responder stuck in a wait state shows as a control wire left high after the last read. Both show within a few hundred cycles of the command. An address or data word latched from the wrong phase, or before the lines settle, appears as a wrong `rsp_data` on the very next pulse. A broken accept guard appears as a second pulse or a request wire rising with no command pending. Phase-ordering faults on the wires are caught in the cycle they happen, by checking the three observed control wires against the drive enables.

// File: rtl/async_rd_pkg.sv
package async_rd_pkg;

  typedef enum logic [2:0] {
    RQ_IDLE,
    RQ_ADDR,
    RQ_REQ,
    RQ_REL,
    RQ_WAIT_D,
    RQ_ACK
  } rq_state_t;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_ACK,
    RS_FETCH,
    RS_DRIVE,
    RS_DRDY,
    RS_DONE
  } rs_state_t;

  function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/rd_word_mem.sv
module rd_word_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/rd_requester.sv
module rd_requester
  import async_rd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rreq_o,
  output logic              ack_o,
  output logic [BUS_W-1:0]  ad_o,
  output logic              ad_en_o,
  input  logic              drdy_i,
  input  logic              ack_i,
  input  logic [BUS_W-1:0]  ad_i
);
  rq_state_t        state;
  logic [1:0]       ctl_s;
  logic             drdy_s;
  logic             ack_s;

  hs_sync2 #(.WIDTH(2)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({drdy_i, ack_i}),
    .q   (ctl_s)
  );
  assign drdy_s = ctl_s[1];
  assign ack_s  = ctl_s[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RQ_IDLE;
      rreq_o    <= 1'b0;
      ack_o     <= 1'b0;
      ad_o      <= '0;
      ad_en_o   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        RQ_IDLE: if (cmd_valid) begin
          ad_o    <= BUS_W'(cmd_addr);
          ad_en_o <= 1'b1;
          state   <= RQ_ADDR;
        end
        RQ_ADDR: begin
          rreq_o <= 1'b1;
          state  <= RQ_REQ;
        end
        RQ_REQ: if (ack_s) begin
          rreq_o  <= 1'b0;
          ad_en_o <= 1'b0;
          state   <= RQ_REL;
        end
        RQ_REL: if (!ack_s) state <= RQ_WAIT_D;
        RQ_WAIT_D: if (drdy_s) begin
          rsp_data <= ad_i[DATA_W-1:0];
          ack_o    <= 1'b1;
          state    <= RQ_ACK;
        end
        RQ_ACK: if (!drdy_s) begin
          ack_o     <= 1'b0;
          rsp_valid <= 1'b1;
          state     <= RQ_IDLE;
        end
        default: state <= RQ_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == RQ_IDLE);
endmodule

// File: rtl/rd_responder.sv
module rd_responder
  import async_rd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic              rreq_i,
  input  logic              ack_i,
  input  logic [BUS_W-1:0]  ad_i,
  output logic              ack_o,
  output logic              drdy_o,
  output logic [BUS_W-1:0]  ad_o,
  output logic              ad_en_o,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [DATA_W-1:0] mem_rdata
);
  rs_state_t  state;
  logic [1:0] ctl_s;
  logic       rreq_s;
  logic       ack_s;

  hs_sync2 #(.WIDTH(2)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({rreq_i, ack_i}),
    .q   (ctl_s)
  );
  assign rreq_s = ctl_s[1];
  assign ack_s  = ctl_s[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RS_IDLE;
      ack_o     <= 1'b0;
      drdy_o    <= 1'b0;
      ad_o      <= '0;
      ad_en_o   <= 1'b0;
      mem_raddr <= '0;
    end else begin
      unique case (state)
        RS_IDLE: if (rreq_s) begin
          mem_raddr <= ad_i[ADDR_W-1:0];
          ack_o     <= 1'b1;
          state     <= RS_ACK;
        end
        RS_ACK: if (!rreq_s) begin
          ack_o <= 1'b0;
          state <= RS_FETCH;
        end
        RS_FETCH: if (!ack_s && !stall) begin
          ad_o    <= BUS_W'(mem_rdata);
          ad_en_o <= 1'b1;
          state   <= RS_DRIVE;
        end
        RS_DRIVE: begin
          drdy_o <= 1'b1;
          state  <= RS_DRDY;
        end
        RS_DRDY: if (ack_s) begin
          drdy_o  <= 1'b0;
          ad_en_o <= 1'b0;
          state   <= RS_DONE;
        end
        RS_DONE: if (!ack_s) state <= RS_IDLE;
        default: state <= RS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/async_rd_link.sv
module async_rd_link
  import async_rd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              req_clk,
  input  logic              req_rst,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              mem_clk,
  input  logic              mem_rst,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              mem_stall,
  output logic              bus_rreq,
  output logic              bus_drdy,
  output logic              bus_ack
);
  localparam int BUS_W = max_w(ADDR_W, DATA_W);

  logic             w_rreq;
  logic             w_drdy;
  logic             w_req_ack;
  logic             w_rsp_ack;
  logic             w_ack;
  logic [BUS_W-1:0] w_req_ad;
  logic [BUS_W-1:0] w_rsp_ad;
  logic             w_req_en;
  logic             w_rsp_en;
  logic [ADDR_W-1:0] w_raddr;
  logic [DATA_W-1:0] w_rdata;

  assign w_ack = w_req_ack | w_rsp_ack;

  rd_requester #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W)) i_req (
    .clk       (req_clk),
    .rst       (req_rst),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rreq_o    (w_rreq),
    .ack_o     (w_req_ack),
    .ad_o      (w_req_ad),
    .ad_en_o   (w_req_en),
    .drdy_i    (w_drdy),
    .ack_i     (w_ack),
    .ad_i      (w_rsp_ad)
  );

  rd_responder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W)) i_rsp (
    .clk       (mem_clk),
    .rst       (mem_rst),
    .stall     (mem_stall),
    .rreq_i    (w_rreq),
    .ack_i     (w_ack),
    .ad_i      (w_req_ad),
    .ack_o     (w_rsp_ack),
    .drdy_o    (w_drdy),
    .ad_o      (w_rsp_ad),
    .ad_en_o   (w_rsp_en),
    .mem_raddr (w_raddr),
    .mem_rdata (w_rdata)
  );

  rd_word_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
    .clk   (mem_clk),
    .we    (fill_en),
    .waddr (fill_addr),
    .wdata (fill_data),
    .raddr (w_raddr),
    .rdata (w_rdata)
  );

  assign bus_rreq = w_rreq;
  assign bus_drdy = w_drdy;
  assign bus_ack  = w_ack;
endmodule

// File: rtl/async_rd_link_chk.sv
module async_rd_link_chk (
  input logic req_clk,
  input logic req_rst,
  input logic mem_clk,
  input logic mem_rst,
  input logic cmd_ready,
  input logic rsp_valid,
  input logic rreq,
  input logic drdy,
  input logic ack,
  input logic req_en,
  input logic rsp_en
);
  AST_RREQ_WITH_ADDR: assert property (@(posedge req_clk) disable iff (req_rst || mem_rst)
    rreq |-> req_en); // R4
  AST_RREQ_DROP_ACKED: assert property (@(posedge req_clk) disable iff (req_rst || mem_rst)
    $fell(rreq) |-> ack); // R5
  AST_NO_CONTENTION: assert property (@(posedge req_clk) disable iff (req_rst || mem_rst)
    !(req_en && rsp_en)); // R6
  AST_VALID_ONE_CYCLE: assert property (@(posedge req_clk) disable iff (req_rst || mem_rst)
    rsp_valid |=> !rsp_valid); // R2
  AST_READY_QUIET: assert property (@(posedge req_clk) disable iff (req_rst || mem_rst)
    cmd_ready |-> (!rreq && !req_en)); // R3
  AST_VALID_LINES_LOW: assert property (@(posedge req_clk) disable iff (req_rst || mem_rst)
    rsp_valid |-> (!rreq && !drdy)); // R8
  AST_DRDY_WITH_DATA: assert property (@(posedge mem_clk) disable iff (req_rst || mem_rst)
    drdy |-> rsp_en); // R6
  AST_DRDY_RISE_NO_REQ: assert property (@(posedge mem_clk) disable iff (req_rst || mem_rst)
    $rose(drdy) |-> !rreq); // R5
  AST_DRDY_DROP_ACKED: assert property (@(posedge mem_clk) disable iff (req_rst || mem_rst)
    $fell(drdy) |-> ack); // R5
endmodule

bind async_rd_link async_rd_link_chk i_chk (
  .req_clk   (req_clk),
  .req_rst   (req_rst),
  .mem_clk   (mem_clk),
  .mem_rst   (mem_rst),
  .cmd_ready (cmd_ready),
  .rsp_valid (rsp_valid),
  .rreq      (w_rreq),
  .drdy      (w_drdy),
  .ack       (w_ack),
  .req_en    (w_req_en),
  .rsp_en    (w_rsp_en)
);

// File: tb/test_async_rd_link.sv
`timescale 1ns/1ps
module test_async_rd_link;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic          req_clk = 1'b0;
  logic          mem_clk = 1'b0;
  logic          req_rst = 1'b1;
  logic          mem_rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic          cmd_ready;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          fill_en = 1'b0;
  logic [AW-1:0] fill_addr = '0;
  logic [DW-1:0] fill_data = '0;
  logic          mem_stall = 1'b0;
  logic          bus_rreq, bus_drdy, bus_ack;

  logic [DW-1:0] ref_mem [DEPTH];
  bit            stall_mode = 1'b0;
  int            n_tests = 0;
  int            n_fail  = 0;

  always #5    req_clk = ~req_clk;
  always #3.65 mem_clk = ~mem_clk;

  async_rd_link #(.ADDR_W(AW), .DATA_W(DW)) i_async_rd_link (
    .req_clk, .req_rst, .cmd_valid, .cmd_addr, .cmd_ready, .rsp_valid, .rsp_data,
    .mem_clk, .mem_rst, .fill_en, .fill_addr, .fill_data, .mem_stall,
    .bus_rreq, .bus_drdy, .bus_ack
  );

  always @(negedge mem_clk) begin
    if (stall_mode) mem_stall = ($urandom % 4) != 0;
    else            mem_stall = 1'b0;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fill_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge mem_clk);
    fill_en = 1'b1; fill_addr = a; fill_data = d;
    @(negedge mem_clk);
    fill_en = 1'b0;
    ref_mem[a] = d;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string req);
    int cnt;
    cnt = 0;
    while (!cmd_ready) @(negedge req_clk);
    cmd_valid = 1'b1; cmd_addr = a;
    @(negedge req_clk);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R3", "ready after accept", cmd_ready, 0);
    while (!rsp_valid && cnt < 3000) begin @(negedge req_clk); cnt++; end
    check(rsp_valid == 1'b1, req, "response seen", rsp_valid, 1);
    check(rsp_data == ref_mem[a], req, "read data", rsp_data, ref_mem[a]);
    check({bus_rreq, bus_drdy, bus_ack} == 3'b000, "R8", "lines at response",
          {bus_rreq, bus_drdy, bus_ack}, 0);
    @(negedge req_clk);
    check(rsp_valid == 1'b0, "R2", "pulse width", rsp_valid, 0);
    check(cmd_ready == 1'b1, "R3", "ready after response", cmd_ready, 1);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge req_clk);
    check(cmd_ready == 1'b1 && rsp_valid == 1'b0, "R1", "ready/valid in reset",
          {cmd_ready, rsp_valid}, 2'b10);
    req_rst = 1'b0;
    mem_rst = 1'b0;
    repeat (3) @(negedge req_clk);
    check(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);
    check(rsp_valid == 1'b0, "R1", "valid after reset", rsp_valid, 0);
    check({bus_rreq, bus_drdy, bus_ack} == 3'b000, "R1", "lines after reset",
          {bus_rreq, bus_drdy, bus_ack}, 0);
  endtask

  task automatic t_fill_all();
    for (int i = 0; i < DEPTH; i++) fill_word(AW'(i), DW'((i * 16'h1357) ^ 16'hA5C3));
  endtask

  task automatic t_single_reads();
    do_read(6'd0, "R2");
    do_read(6'd63, "R2");
    do_read(6'd21, "R2");
    do_read(6'd42, "R2");
  endtask

  task automatic t_stalled_reads();
    stall_mode = 1'b1;
    for (int i = 0; i < 8; i++) do_read(AW'(i * 9 + 3), "R7");
    stall_mode = 1'b0;
  endtask

  task automatic t_busy_ignored();
    int pulses;
    int cnt;
    pulses = 0;
    cnt = 0;
    while (!cmd_ready) @(negedge req_clk);
    cmd_valid = 1'b1; cmd_addr = 6'd5;
    @(negedge req_clk);
    cmd_addr = 6'd50;
    repeat (6) @(negedge req_clk);
    cmd_valid = 1'b0;
    while (!rsp_valid && cnt < 3000) begin @(negedge req_clk); cnt++; end
    check(rsp_data == ref_mem[5], "R3", "first command data", rsp_data, ref_mem[5]);
    repeat (300) begin
      @(negedge req_clk);
      if (rsp_valid || bus_rreq) pulses++;
    end
    check(pulses == 0, "R3", "busy command ignored", pulses, 0);
  endtask

  task automatic t_overwrite();
    fill_word(6'd17, 16'hBEEF);
    do_read(6'd17, "R9");
    fill_word(6'd17, 16'h0042);
    do_read(6'd17, "R9");
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < 16; i++) do_read(AW'((i * 23 + 7) % DEPTH), "R10");
  endtask

  initial begin
    t_reset();
    t_fill_all();
    t_single_reads();
    t_stalled_reads();
    t_busy_ignored();
    t_overwrite();
    t_back_to_back();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule